// File: doc/BRIEF.md
# Keyed-Stop Watchdog Timer

This block is a watchdog counter on a simple register bus. It leaves every reset (hardware or software) already running. On each slow-domain tick it counts up from a programmable start value. When it passes its all-ones value it raises a one-cycle reset request and starts again from the start value. Software can halt it only with a two-word key sequence. A different two-word sequence starts it again. Any other order leaves the counter as it was.

Each key write is posted. The bus side latches the value and raises a pending flag. The value reaches the sequencer a fixed number of slow ticks later. Software polls the flag before it writes the next key, and a key write made while the flag is set is dropped. The slow domain is modelled as a tick enable in the bus clock.

A control bit starts a soft reset. The soft reset restores every register, clears any posted key and sets the counter running again. A status bit reads 0 while the soft reset is in progress. The bus has no back-pressure. Each access completes in the cycle in which `bus_sel` is high, and read data is combinational from the address.

Top module: `wdt_keyed_top`

## Requirements
- R1: After hardware reset the watchdog counts, the done bit reads 1, the pending bit reads 0, the key register reads 0 and the start-value register reads LOAD_DEF (0).
- R2: Register offsets are as follows. Control is at 0x10, and writing bit 0 as 1 starts a soft reset. Status is at 0x14, with the done bit at bit 0. The counter is at 0x28 and reads only. The start value is at 0x2C. Pending is at 0x34, with the posted-key flag at bit 4. The key register is at 0x48. Key values are compared on the low 16 bits only.
- R3: A key of 0xAAAA followed by a key of 0x5555 stops the counter.
- R4: After 0xAAAA, any key other than 0x5555 cancels the stop sequence and the counter keeps running. A new 0xAAAA starts the sequence over, and 0x5555 with no 0xAAAA before it has no effect.
- R5: A key of 0xBBBB followed by 0x4444 restarts a stopped counter. Any other key between the two cancels the restart.
- R6: An accepted key write sets the pending bit at the write edge. The bit clears, and the key acts, at the edge that consumes the third tick after the write.
- R7: A key write made while the pending bit is set is ignored. It changes neither the key readback nor the sequence.
- R8: While running, the counter adds 1 on each tick. On the tick where it is all ones, `wdt_reset_req` is high for exactly one cycle and the counter reloads the start value. A write to the start-value register also loads the counter at once.
- R9: While stopped, the counter holds its value and `wdt_reset_req` stays low.
- R10: A soft reset restores the state of R1, including the running counter. The done bit reads 0 for the 4 cycles after the write edge and 1 after that. Bus writes made during those cycles are ignored.
- R11: The key register reads back the last accepted key. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| tmr_tick | input | 1 | One-cycle enable marking each slow-domain clock |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| wdt_reset_req | output | 1 | One-cycle reset request on expiry |

## Verification
On every cycle, the assertions check the following. The expiry pulse lasts one cycle. A stopped counter holds its value. An accepted key write raises pending, and a key write made while pending is already set leaves the latched key unchanged. The run state falls only on a second stop key and rises only on a second start key or a soft reset. The done bit drops after a soft-reset write and returns after the count. Only the bench scenarios can show the order-dependent sequence outcomes across many key patterns, the exact tick count of the posting delay, the pulse rate for a given start value, and the full restore of state after a soft reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] A_CTRL = 8'h10;
  localparam logic [7:0] A_STAT = 8'h14;
  localparam logic [7:0] A_CNT  = 8'h28;
  localparam logic [7:0] A_LOAD = 8'h2C;
  localparam logic [7:0] A_PEND = 8'h34;
  localparam logic [7:0] A_KEY  = 8'h48;

  localparam logic [15:0] K_STOP1 = 16'hAAAA;
  localparam logic [15:0] K_STOP2 = 16'h5555;
  localparam logic [15:0] K_RUN1  = 16'hBBBB;
  localparam logic [15:0] K_RUN2  = 16'h4444;

  localparam int PEND_BIT = 4;

  typedef enum logic [1:0] {SQ_IDLE, SQ_STOP, SQ_RUN} seq_t;
endpackage

// File: rtl/wdt_post.sv
module wdt_post #(
  parameter int POST_TICKS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        tick,
  input  logic        key_wr,
  input  logic [15:0] key_wdata,
  output logic        pend,
  output logic [15:0] key_q,
  output logic        apply
);
  localparam int TCW = (POST_TICKS > 1) ? $clog2(POST_TICKS) : 1;
  localparam logic [TCW-1:0] TC_LAST = TCW'(POST_TICKS - 1);

  logic [TCW-1:0] tc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      tc    <= '0;
      key_q <= '0;
    end else if (clr) begin
      pend  <= 1'b0;
      tc    <= '0;
      key_q <= '0;
    end else if (key_wr && !pend) begin
      key_q <= key_wdata;
      pend  <= 1'b1;
      tc    <= '0;
    end else if (pend && tick) begin
      if (tc == TC_LAST) pend <= 1'b0;
      else               tc   <= tc + 1'b1;
    end
  end

  assign apply = pend && tick && (tc == TC_LAST) && !clr;

  // R6
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && key_wr && !clr) |=> pend);

  // R7
  pend_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && key_wr && !clr) |=> $stable(key_q));
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        apply,
  input  logic [15:0] key,
  output logic        run
);
  seq_t seq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq <= SQ_IDLE;
      run <= 1'b1;
    end else if (clr) begin
      seq <= SQ_IDLE;
      run <= 1'b1;
    end else if (apply) begin
      if (key == K_STOP1)                          seq <= SQ_STOP;
      else if (key == K_RUN1)                      seq <= SQ_RUN;
      else if (key == K_STOP2 && seq == SQ_STOP) begin
        run <= 1'b0;
        seq <= SQ_IDLE;
      end else if (key == K_RUN2 && seq == SQ_RUN) begin
        run <= 1'b1;
        seq <= SQ_IDLE;
      end else                                     seq <= SQ_IDLE;
    end
  end

  // R3
  run_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> ($past(apply) && $past(key) == K_STOP2));

  // R5
  run_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> ($past(clr) || ($past(apply) && $past(key) == K_RUN2)));
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int          CW       = 32,
  parameter logic [CW-1:0] LOAD_DEF = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          run,
  input  logic          load_wr,
  input  logic [CW-1:0] wr_val,
  input  logic [CW-1:0] load_q,
  output logic [CW-1:0] cnt,
  output logic          rst_req
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= LOAD_DEF;
      rst_req <= 1'b0;
    end else if (clr) begin
      cnt     <= LOAD_DEF;
      rst_req <= 1'b0;
    end else if (load_wr) begin
      cnt     <= wr_val;
      rst_req <= 1'b0;
    end else if (run && tick) begin
      if (cnt == CNT_MAX) begin
        cnt     <= load_q;
        rst_req <= 1'b1;
      end else begin
        cnt     <= cnt + 1'b1;
        rst_req <= 1'b0;
      end
    end else begin
      rst_req <= 1'b0;
    end
  end

  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R9
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr && !load_wr) |=> ($stable(cnt) && !rst_req));
endmodule

// File: rtl/wdt_regif.sv
module wdt_regif
  import wdt_pkg::*;
#(
  parameter int            CW       = 32,
  parameter logic [CW-1:0] LOAD_DEF = '0,
  parameter int            SRST_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [7:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [CW-1:0] cnt,
  input  logic          pend,
  input  logic [15:0]   key_q,
  output logic          clr,
  output logic          key_wr,
  output logic          load_wr,
  output logic [CW-1:0] load_q
);
  localparam int SW = $clog2(SRST_CYC + 1);
  localparam logic [SW-1:0] SR_START = SW'(SRST_CYC);

  logic [SW-1:0] sr_cnt;
  logic          busy, wr, srst_wr, done;

  assign busy    = (sr_cnt != '0);
  assign done    = !busy;
  assign wr      = bus_sel && bus_we && !busy;
  assign srst_wr = wr && (bus_addr == A_CTRL) && bus_wdata[0];
  assign key_wr  = wr && (bus_addr == A_KEY);
  assign load_wr = wr && (bus_addr == A_LOAD);
  assign clr     = srst_wr || busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr_cnt <= '0;
    else if (srst_wr) sr_cnt <= SR_START;
    else if (busy)    sr_cnt <= sr_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       load_q <= LOAD_DEF;
    else if (clr)     load_q <= LOAD_DEF;
    else if (load_wr) load_q <= bus_wdata[CW-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STAT: bus_rdata[0]        = done;
      A_CNT:  bus_rdata[CW-1:0]   = cnt;
      A_LOAD: bus_rdata[CW-1:0]   = load_q;
      A_PEND: bus_rdata[PEND_BIT] = pend;
      A_KEY:  bus_rdata[15:0]     = key_q;
      default: bus_rdata = '0;
    endcase
  end

  // R10
  srst_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_wr |=> !done);

  // R10
  srst_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_cnt == SW'(1)) |=> done);
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top #(
  parameter int          CW         = 32,
  parameter logic [CW-1:0] LOAD_DEF = '0,
  parameter int          POST_TICKS = 3,
  parameter int          SRST_CYC   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tmr_tick,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdt_reset_req
);
  logic          clr, key_wr, load_wr, pend, apply, run;
  logic [15:0]   key_q;
  logic [CW-1:0] load_q, cnt;

  wdt_regif #(.CW(CW), .LOAD_DEF(LOAD_DEF), .SRST_CYC(SRST_CYC)) u_regif (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt), .pend(pend), .key_q(key_q), .clr(clr), .key_wr(key_wr),
    .load_wr(load_wr), .load_q(load_q)
  );

  wdt_post #(.POST_TICKS(POST_TICKS)) u_post (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tmr_tick), .key_wr(key_wr),
    .key_wdata(bus_wdata[15:0]), .pend(pend), .key_q(key_q), .apply(apply)
  );

  wdt_keyseq u_seq (
    .clk(clk), .rst_n(rst_n), .clr(clr), .apply(apply), .key(key_q), .run(run)
  );

  wdt_core #(.CW(CW), .LOAD_DEF(LOAD_DEF)) u_core (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tmr_tick), .run(run),
    .load_wr(load_wr), .wr_val(bus_wdata[CW-1:0]), .load_q(load_q),
    .cnt(cnt), .rst_req(wdt_reset_req)
  );
endmodule

// File: tb/sim_wdt_keyed_top.sv
module sim_wdt_keyed_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr_tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_reset_req;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  wdt_keyed_top u0 (
    .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wdt_reset_req(wdt_reset_req)
  );

  always #2 clk = ~clk;

  // slow domain: one tick in every four bus cycles
  initial begin
    logic [1:0] ph = '0;
    forever begin
      @(negedge clk);
      tmr_tick <= (ph == 2'd3);
      ph = ph + 1'b1;
    end
  end

  // key value, expected running state afterwards
  localparam int NV = 16;
  localparam logic [16:0] VEC [NV] = '{
    {16'hAAAA, 1'b1},  // R3 first half only
    {16'h1234, 1'b1},  // R4 cancel
    {16'h5555, 1'b1},  // R4 second half alone
    {16'hAAAA, 1'b1},  // R3
    {16'h5555, 1'b0},  // R3 stopped
    {16'h5555, 1'b0},  // R9 stays stopped
    {16'hBBBB, 1'b0},  // R5 first half
    {16'h0000, 1'b0},  // R5 cancel
    {16'h4444, 1'b0},  // R5 alone
    {16'hBBBB, 1'b0},  // R5
    {16'h4444, 1'b1},  // R5 running again
    {16'hAAAA, 1'b1},  // R4
    {16'hAAAA, 1'b1},  // R4 restart
    {16'h5555, 1'b0},  // R4 stop after restart
    {16'hBBBB, 1'b0},  // R5
    {16'h4444, 1'b1}   // R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_pend();
    logic [31:0] v;
    for (int i = 0; i < 100; i++) begin
      bread(8'h34, v);
      if (v[4] == 1'b0) break;
      @(negedge clk);
    end
  endtask

  task automatic running(output logic r);
    logic [31:0] a, b;
    @(negedge clk);
    bread(8'h28, a);
    repeat (12) @(negedge clk);
    bread(8'h28, b);
    r = (a != b);
  endtask

  task automatic count_pulses(output int p);
    int n = 0;
    p = 0;
    while (n < 12) begin
      @(negedge clk);
      #1;
      if (wdt_reset_req) p++;
      if (tmr_tick) n++;
    end
    @(negedge clk);
    #1;
    if (wdt_reset_req) p++;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hang expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v, w;
    logic r;
    int p, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bread(8'h14, v); chk("R1 done", v, 32'h1);
    bread(8'h34, v); chk("R1 pend", v, 32'h0);
    bread(8'h48, v); chk("R1 key", v, 32'h0);
    bread(8'h2C, v); chk("R1 load", v, 32'h0);
    running(r);      chk("R1 running", {31'b0, r}, 32'h1);

    // table walk: R3 R4 R5 R11
    for (int i = 0; i < NV; i++) begin
      bwrite(8'h48, {16'hF00D, VEC[i][16:1]});
      wait_pend();
      bread(8'h48, v);
      chk($sformatf("R11 key readback vec %0d", i), v, {16'h0, VEC[i][16:1]});
      running(r);
      chk($sformatf("R2 key sequence vec %0d", i), {31'b0, r}, {31'b0, VEC[i][0]});
    end

    // R6 pending spans exactly three ticks
    bwrite(8'h48, 32'h0000_1111);
    bread(8'h34, v); chk("R6 pend set", v, 32'h10);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      #1;
      if (tmr_tick) n++;
      if (n == 3) break;
      @(negedge clk);
    end
    bread(8'h34, v); chk("R6 pend before third tick", v, 32'h10);
    @(negedge clk);
    bread(8'h34, v); chk("R6 pend cleared", v, 32'h0);

    // R7 write while pending is dropped
    bwrite(8'h48, 32'h0000_AAAA);
    bwrite(8'h48, 32'h0000_1234);
    wait_pend();
    bread(8'h48, v); chk("R7 key kept", v, 32'h0000_AAAA);
    bwrite(8'h48, 32'h0000_5555);
    wait_pend();
    running(r); chk("R7 sequence intact", {31'b0, r}, 32'h0);
    bwrite(8'h48, 32'h0000_BBBB); wait_pend();
    bwrite(8'h48, 32'h0000_4444); wait_pend();

    // R8 expiry pulses: start value three below wrap
    bwrite(8'h2C, 32'hFFFF_FFFD);
    count_pulses(p);
    chk("R8 pulses per 12 ticks", p, 32'd4);
    bread(8'h2C, v); chk("R8 load readback", v, 32'hFFFF_FFFD);

    // R9 stopped: no pulses, counter held
    bwrite(8'h48, 32'h0000_AAAA); wait_pend();
    bwrite(8'h48, 32'h0000_5555); wait_pend();
    count_pulses(p);
    chk("R9 no pulses", p, 32'd0);
    running(r); chk("R9 held", {31'b0, r}, 32'h0);

    // R10 soft reset
    bwrite(8'h10, 32'h1);
    for (int i = 0; i < 4; i++) begin
      bread(8'h14, v); chk("R10 done low", v, 32'h0);
      if (i == 1) begin
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h2C; bus_wdata = 32'h1234;
      end
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
    end
    bread(8'h14, v); chk("R10 done high", v, 32'h1);
    bread(8'h2C, v); chk("R10 load default", v, 32'h0);
    bread(8'h48, v); chk("R10 key cleared", v, 32'h0);
    bread(8'h34, v); chk("R10 pend cleared", v, 32'h0);
    running(r);      chk("R10 running again", {31'b0, r}, 32'h1);

    // R11 reads have no side effects
    bwrite(8'h48, 32'h0000_AAAA); wait_pend();
    bread(8'h48, v); bread(8'h48, w);
    chk("R11 repeat read", w, v);
    bread(8'h34, v); bread(8'h14, v);
    bwrite(8'h48, 32'h0000_5555); wait_pend();
    running(r); chk("R11 sequence unaffected by reads", {31'b0, r}, 32'h0);

    finish_run();
  end
endmodule